// File: doc/BRIEF.md
# Cascaded Serial Converter Write Controller

This block is a host-side master that loads 12-bit output codes into a daisy chain of serial digital-to-analog converters. A single valid/ready handshake hands over one code per converter in a packed vector. The controller then pulls the active-low select line down once and shifts out one 16-bit frame per converter. Each frame holds zero fill bits followed by the code, most significant bit first. When the last frame is out, select rises once and every converter in the chain loads its new code at the same moment.

The serial clock idles low. Data changes while the clock is low and is captured by the receivers on the rising edge. The clock period comes from a divider parameter. The high and low phase lengths, the lead time from select falling to the first rising edge, and the select-high gap between transfers are all derived from picosecond minimums and the system clock period, so that the nanosecond limits of the converters hold at the configured system frequency.

Code slot 0 belongs to the converter wired directly to the controller. The frame for the farthest converter is sent first, so that after N frames every converter holds its own frame.

Top module: `cascade_dac_writer`

## Requirements
- R1: Each converter's 16-bit frame is four fill bits driven as 0, followed by its 12-bit code MSB first. After the transfer, bits 15:12 of every converter's shift register are 0 and bits 11:0 hold the code.
- R2: `in_codes[i*12 +: 12]` is the code for converter i. Converter 0 is nearest the controller. Frames are sent from index N-1 down to index 0, so converter i ends up holding code i.
- R3: One select-low window carries exactly 16*N rising serial clock edges, and select rises exactly once at the end of it.
- R4: The serial clock is low whenever select is high, including after reset.
- R5: Every high phase lasts HI = max(DIV/2, ceil(35000 ps / Tsys)) system cycles. Every low phase between two rising edges lasts LO = max(DIV - DIV/2, ceil(35000 ps / Tsys)) system cycles. The defaults (DIV=8, Tsys=8000 ps) give 5 and 5.
- R6: From select falling to the first rising edge there are LEAD = max(LO, ceil(20000 ps / Tsys)) system cycles, which is 5 at the defaults.
- R7: Between two windows, select stays high for at least GAP_CYC system cycles (default 4), and `in_ready` is low whenever select is low.
- R8: Serial data holds steady while the serial clock is high and changes only while it is low.
- R9: After reset, select is high, the serial clock is low and `in_ready` is high.
- R10: Changes on `in_codes` and `in_valid` during a transfer have no effect on the frames being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A code set is offered |
| in_ready | output | 1 | Controller is idle and accepts a code set |
| in_codes | input | NUM_DEV*CODE_W | Packed codes; slot i is the converter i places from the controller |
| dac_sel_n | output | 1 | Active-low select shared by the chain |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data into the first converter |

## Verification
A corrupted shift register or a wrong slot order shows up as a wrong code in the chain model once select rises, about 10*16*N system cycles after acceptance. A phase counter loaded with the wrong value shows as a high or low run of the wrong length at the very next serial clock edge. A bit counter that is off ends the window with a rise count other than 16*N, which is seen within that window. A gap state that is cut short shows as a select-high run below the minimum when the next transfer follows back to back.

// File: rtl/cdw_pkg.sv
package cdw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_GAP
   } cdw_state_e;

   function automatic int cdw_ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int cdw_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dac_phase_timer.sv
// Down-counter that measures one phase; done is high when it sits at zero.
module dac_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // the counter rests at zero until reloaded (R5 phase lengths rely on this)
   p_timer_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && done) |=> done);
endmodule

// File: rtl/dac_frame_packer.sv
// Builds the chain image: farthest converter's frame in the top bits.
module dac_frame_packer #(
   parameter int NUM_DEV = 3,
   parameter int CODE_W  = 12,
   parameter int FILL_W  = 4,
   localparam int FRAME_W = FILL_W + CODE_W,
   localparam int TOTAL_W = NUM_DEV * FRAME_W
) (
   input  logic [NUM_DEV*CODE_W-1:0] codes,
   output logic [TOTAL_W-1:0]        image
);
   for (genvar i = 0; i < NUM_DEV; i++) begin : g_slot
      if (FILL_W > 0) begin : g_fill
         assign image[i*FRAME_W +: FRAME_W] = {{FILL_W{1'b0}}, codes[i*CODE_W +: CODE_W]};
      end else begin : g_nofill
         assign image[i*FRAME_W +: FRAME_W] = codes[i*CODE_W +: CODE_W];
      end
   end
endmodule

// File: rtl/cascade_dac_writer.sv
module cascade_dac_writer
   import cdw_pkg::*;
#(
   parameter int NUM_DEV       = 3,
   parameter int CODE_W        = 12,
   parameter int FILL_W        = 4,
   parameter int SCLK_DIV      = 8,
   parameter int SYS_PERIOD_PS = 8000,
   parameter int MIN_PHASE_PS  = 35000,
   parameter int MIN_SETUP_PS  = 20000,
   parameter int MIN_SELHI_PS  = 20000,
   parameter int GAP_CYC       = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [NUM_DEV*CODE_W-1:0] in_codes,
   output logic                      dac_sel_n,
   output logic                      dac_sclk,
   output logic                      dac_sdo
);
   localparam int FRAME_W   = FILL_W + CODE_W;
   localparam int TOTAL_W   = NUM_DEV * FRAME_W;
   localparam int PH_MIN    = cdw_ceil_div(MIN_PHASE_PS, SYS_PERIOD_PS);
   localparam int HI_CYC    = cdw_max(SCLK_DIV / 2, PH_MIN);
   localparam int LO_CYC    = cdw_max(SCLK_DIV - SCLK_DIV / 2, PH_MIN);
   localparam int SU_CYC    = cdw_ceil_div(MIN_SETUP_PS, SYS_PERIOD_PS);
   localparam int LEAD_CYC  = cdw_max(LO_CYC, SU_CYC);
   localparam int SELHI_CYC = cdw_ceil_div(MIN_SELHI_PS, SYS_PERIOD_PS);
   localparam int MAX_PH    = cdw_max(cdw_max(HI_CYC, LEAD_CYC), GAP_CYC);
   localparam int CNT_W     = $clog2(MAX_PH + 1);
   localparam int BIT_W     = $clog2(TOTAL_W + 1);

   // elaboration-time parameter checks
   if (NUM_DEV < 1)          begin : g_bad_dev   $error("NUM_DEV must be at least 1"); end
   if (CODE_W < 1)           begin : g_bad_code  $error("CODE_W must be at least 1"); end
   if (SCLK_DIV < 2)         begin : g_bad_div   $error("SCLK_DIV must be at least 2"); end
   if (GAP_CYC < SELHI_CYC)  begin : g_bad_gap   $error("GAP_CYC below select-high minimum"); end
   if (GAP_CYC < 1)          begin : g_bad_gap0  $error("GAP_CYC must be at least 1"); end

   cdw_state_e         state_q;
   logic [TOTAL_W-1:0] shreg_q;
   logic [TOTAL_W-1:0] image;
   logic [BIT_W-1:0]   bits_q;
   logic               tmr_load;
   logic [CNT_W-1:0]   tmr_val;
   logic               tmr_done;
   logic               last_bit;

   dac_frame_packer #(
      .NUM_DEV (NUM_DEV),
      .CODE_W  (CODE_W),
      .FILL_W  (FILL_W)
   ) u_pack (
      .codes (in_codes),
      .image (image)
   );

   dac_phase_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   assign last_bit = (bits_q == BIT_W'(TOTAL_W - 1));

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (in_valid) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(LEAD_CYC - 1);
         end
         ST_LEAD, ST_LOW: if (tmr_done) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HI_CYC - 1);
         end
         ST_HIGH: if (tmr_done) begin
            tmr_load = 1'b1;
            tmr_val  = last_bit ? CNT_W'(GAP_CYC - 1) : CNT_W'(LO_CYC - 1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shreg_q <= '0;
         bits_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (in_valid) begin
               shreg_q <= image;
               bits_q  <= '0;
               state_q <= ST_LEAD;
            end
            ST_LEAD, ST_LOW: if (tmr_done) state_q <= ST_HIGH;
            ST_HIGH: if (tmr_done) begin
               shreg_q <= {shreg_q[TOTAL_W-2:0], 1'b0};
               bits_q  <= bits_q + 1'b1;
               state_q <= last_bit ? ST_GAP : ST_LOW;
            end
            ST_GAP: if (tmr_done) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (state_q == ST_IDLE);
   assign dac_sel_n = (state_q == ST_IDLE) || (state_q == ST_GAP);
   assign dac_sclk  = (state_q == ST_HIGH);
   assign dac_sdo   = shreg_q[TOTAL_W-1];

   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sel_n |-> !dac_sclk);

   p_sdo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dac_sclk) && dac_sclk) |-> $stable(dac_sdo));

   p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_sel_n |-> !in_ready);

   p_bits_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bits_q <= BIT_W'(TOTAL_W));

   p_sel_rise_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_sel_n) |-> (bits_q == BIT_W'(TOTAL_W)));

   p_first_edge_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_sel_n) |-> !dac_sclk);
endmodule

// File: tb/cascade_dac_writer_test.sv
module cascade_dac_writer_test;
   localparam int N    = 3;
   localparam int CW   = 12;
   localparam int HI   = 5;
   localparam int LO   = 5;
   localparam int LEAD = 5;
   localparam int GAP  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [N*CW-1:0] in_codes = '0;
   logic in_ready, sel, sclk, sdo;

   always #4 clk = ~clk;

   cascade_dac_writer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_codes(in_codes), .dac_sel_n(sel), .dac_sclk(sclk), .dac_sdo(sdo)
   );

   int tests = 0, fails = 0;
   bit done_flag = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // chain model and timing monitor
   logic [15:0] dev [N];
   logic [15:0] lat [N];
   logic prev_sclk = 0, prev_sel = 1, prev_sdo = 0, seen = 0;
   int hi_run = 0, lo_run = 0, sel_hi_run = 0, rises = 0, win_rises = 0;
   int lead_len = 0, viol_hi = 0, viol_lo = 0, viol_sdo = 0, viol_idle = 0, viol_rdy = 0;
   int gap_min = 1000000, windows = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sel) begin
            if (sclk) viol_idle++;
            sel_hi_run++;
         end
         if (!sel && in_ready) viol_rdy++;
         if (prev_sel && !sel) begin
            if (seen && sel_hi_run < gap_min) gap_min = sel_hi_run;
            sel_hi_run = 0; rises = 0; lo_run = 0; hi_run = 0;
         end
         if (!sel) begin
            if (sclk && !prev_sclk) begin
               if (rises == 0) lead_len = lo_run;
               else if (lo_run != LO) viol_lo++;
               for (int k = N-1; k > 0; k--) dev[k] = {dev[k][14:0], dev[k-1][15]};
               dev[0] = {dev[0][14:0], sdo};
               rises++;
               hi_run = 0;
            end
            if (!sclk && prev_sclk) begin
               if (hi_run != HI) viol_hi++;
               lo_run = 0;
            end
            if (sclk && prev_sclk && sdo != prev_sdo) viol_sdo++;
            if (sclk) hi_run++; else lo_run++;
         end
         if (sel && !prev_sel) begin
            if (prev_sclk && hi_run != HI) viol_hi++;
            for (int k = 0; k < N; k++) lat[k] = dev[k];
            win_rises = rises;
            windows++;
            seen = 1;
         end
      end
      prev_sclk = sclk; prev_sel = sel; prev_sdo = sdo;
   end

   task automatic send(input logic [N*CW-1:0] codes);
      int w0 = windows;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_codes = codes; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      while (windows == w0) @(negedge clk);
   endtask

   task automatic verify(input logic [N*CW-1:0] codes, input string name);
      for (int i = 0; i < N; i++) begin
         check(lat[i][11:0] == codes[i*CW +: CW], {"R2 ", name, " code slot"},
               int'(lat[i][11:0]), int'(codes[i*CW +: CW]));
         check(lat[i][15:12] == 4'h0, {"R1 ", name, " fill bits"}, int'(lat[i][15:12]), 0);
      end
      check(win_rises == 16*N, {"R3 ", name, " rising edges"}, win_rises, 16*N);
      check(lead_len == LEAD, {"R6 ", name, " lead cycles"}, lead_len, LEAD);
      check(viol_hi == 0, {"R5 ", name, " high phases"}, viol_hi, 0);
      check(viol_lo == 0, {"R5 ", name, " low phases"}, viol_lo, 0);
   endtask

   task automatic t_reset();
      check(sel == 1'b1, "R9 select after reset", int'(sel), 1);
      check(sclk == 1'b0, "R9 sclk after reset", int'(sclk), 0);
      check(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);
   endtask

   task automatic t_pattern(input logic [N*CW-1:0] codes, input string name);
      send(codes);
      verify(codes, name);
   endtask

   task automatic t_ignore();
      logic [N*CW-1:0] a = {12'h123, 12'h456, 12'h789};
      int w0 = windows;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_codes = a; in_valid = 1'b1;
      @(negedge clk);
      in_codes = {12'hBAD, 12'hBAD, 12'hBAD};
      repeat (100) @(negedge clk);
      in_valid = 1'b0;
      while (windows == w0) @(negedge clk);
      check(in_ready == 1'b0, "R10 still in gap after window", int'(in_ready), 0);
      verify(a, "R10 mid-transfer change");
      check(windows == w0 + 1, "R10 no extra window", windows, w0 + 1);
   endtask

   task automatic t_back_to_back();
      logic [N*CW-1:0] b = {12'h0F0, 12'hF0F, 12'h3C3};
      int w0 = windows;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_codes = b; in_valid = 1'b1;
      while (windows < w0 + 2) @(negedge clk);
      in_valid = 1'b0;
      verify(b, "R7 back to back");
      check(gap_min >= GAP, "R7 select high gap", gap_min, GAP);
      check(viol_rdy == 0, "R7 ready while busy", viol_rdy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pattern({12'h003, 12'h002, 12'h001}, "incrementing");
      t_pattern({12'hFFF, 12'hFFF, 12'hFFF}, "all ones");
      t_pattern({12'h000, 12'h000, 12'h000}, "all zeros");
      t_pattern({12'hA5A, 12'h5A5, 12'h800}, "alternating");
      t_ignore();
      t_back_to_back();
      repeat (20) @(negedge clk);
      check(viol_sdo == 0, "R8 data stable while sclk high", viol_sdo, 0);
      check(viol_idle == 0, "R4 sclk low while deselected", viol_idle, 0);
      check(sel == 1'b1 && sclk == 1'b0, "R4 idle lines", int'(sclk), 0);
      if (!done_flag) begin
         done_flag = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         check(1'b0, "watchdog expired", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule